// File: doc/BRIEF.md
# Serial Flash Status Protection Controller

This block keeps the 8-bit status byte of a serial NOR flash model and rules on every decoded write-type command before it reaches the array. A command arrives as a one-cycle strobe with a 3-bit code, an address and a data byte. One cycle later the block answers with an accept or reject flag. An accepted program, erase or status write raises a busy flag for a fixed number of cycles, set by a parameter for each operation class.

Four conditions can reject a command: the write-enable latch is clear, the target address falls in the protected upper part of the array, a chip erase is requested while any protection is configured, or the status write is hardware-locked by the lock bit together with the active-low write-protect pin. The lock bit and the protection code are kept in flops that hold their value until reset. A read-status request returns the current byte on a separate output one cycle later.

Top module: `sfp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and busy is low. Status layout: bit 7 = lock (SRP), bits 6:5 = reserved, bits 4:2 = protection code BP, bit 1 = WEL, bit 0 = WIP.
- R2: When idle, write-enable (code 0) sets WEL and write-disable (code 1) clears it. Both are accepted.
- R3: While WEL is 0, status write (2), page program (3), sector erase (4), block erase (5) and chip erase (6) are rejected.
- R4: BP code k from 1 to 6 protects the addresses at or above 2^ADDR_W − 2^(ADDR_W−7+k). Code 0 protects nothing and code 7 protects everything. A program, sector erase or block erase whose address is protected is rejected.
- R5: Chip erase is accepted only when BP is 000.
- R6: When the lock bit is 1 and wp_ni is low, a status write is rejected and the lock bit and BP stay unchanged.
- R7: Any command that arrives while busy is rejected, including write-enable.
- R8: An accepted status write, program or erase holds WIP and busy_o high for exactly T_WRSR, T_PP, T_ERASE or T_CE cycles. WEL clears when that time ends.
- R9: A rejected command changes nothing, and WEL stays set.
- R10: An accepted status write loads only bit 7 and bits 4:2 from the data byte. Reserved bits always read 0, and the data bits in the WEL and WIP positions have no effect.
- R11: Each command gets exactly one response (resp_valid_o) in the cycle after the strobe, carrying the accept flag. Code 7 is always rejected and has no effect.
- R12: A read-status request returns the status byte as it stood in the request cycle, on rd_data_o with rd_valid_o, one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| cmd_addr_i | input | ADDR_W | Target address for program and erase |
| cmd_data_i | input | 8 | Data byte for the status write |
| wp_ni | input | 1 | Write-protect pin, active low |
| rd_status_i | input | 1 | Read-status request |
| status_o | output | 8 | Live status byte |
| rd_valid_o | output | 1 | Read-status response valid |
| rd_data_o | output | 8 | Read-status response byte |
| resp_valid_o | output | 1 | Command response valid |
| resp_accept_o | output | 1 | Command accepted |
| busy_o | output | 1 | Operation in progress (WIP) |

## Verification
The bench builds the block with the default ADDR_W of 17 and shortens the busy times to 4, 6, 9 and 15 cycles. With these values each operation class can be told apart by its measured busy length, and every class, including chip erase, completes within a short run. The 17-bit address puts the protection boundaries at concrete values, 0x1E000 for code 3 and 0x1F800 for code 1, so the addresses just below and at each boundary are driven directly.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [2:0] {
    CMD_WREN = 3'd0,
    CMD_WRDI = 3'd1,
    CMD_WRSR = 3'd2,
    CMD_PP   = 3'd3,
    CMD_SE   = 3'd4,
    CMD_BE   = 3'd5,
    CMD_CE   = 3'd6,
    CMD_NONE = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    OP_SR    = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_CHIP  = 2'd3
  } op_e;

  localparam int unsigned BP_W    = 3;
  localparam int unsigned BP_LVLS = 1 << BP_W;
  // bits loaded by a status write: lock bit and protection code
  localparam logic [7:0]  NV_MASK = 8'h9C;
  localparam int unsigned SRP_BIT = 7;
  localparam int unsigned BP_LSB  = 2;
endpackage

// File: rtl/sfp_range_check.sv
module sfp_range_check
  import sfp_pkg::*;
#(
  parameter int unsigned ADDR_W = 17
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W:0] TOP = {1'b1, {ADDR_W{1'b0}}};

  logic [BP_LVLS-1:0] lvl_hit;

  assign lvl_hit[0]         = 1'b0;
  assign lvl_hit[BP_LVLS-1] = 1'b1;

  // code k guards the top 2^(k-1)/64 of the array
  for (genvar k = 1; k < BP_LVLS - 1; k++) begin : g_lvl
    localparam logic [ADDR_W:0] SPAN = TOP >> (BP_LVLS - 1 - k);
    localparam logic [ADDR_W:0] BASE = TOP - SPAN;
    assign lvl_hit[k] = ({1'b0, addr_i} >= BASE);
  end

  assign prot_o = lvl_hit[bp_i];
endmodule

// File: rtl/sfp_busy_timer.sv
module sfp_busy_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1)) && !load_i;

  p_load_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && (load_val_i != '0) |=> busy_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/sfp_cmd_gate.sv
module sfp_cmd_gate
  import sfp_pkg::*;
(
  input  logic            cmd_valid_i,
  input  cmd_e            cmd_i,
  input  logic            busy_i,
  input  logic            wel_i,
  input  logic            srp_i,
  input  logic [BP_W-1:0] bp_i,
  input  logic            wp_ni,
  input  logic            addr_prot_i,
  output logic            accept_o,
  output logic            start_o,
  output op_e             op_o
);
  logic hw_lock;
  assign hw_lock = srp_i && !wp_ni;

  always_comb begin
    accept_o = 1'b0;
    op_o     = OP_SR;
    if (cmd_valid_i && !busy_i) begin
      unique case (cmd_i)
        CMD_WREN, CMD_WRDI: accept_o = 1'b1;
        CMD_WRSR: begin
          accept_o = wel_i && !hw_lock;
          op_o     = OP_SR;
        end
        CMD_PP: begin
          accept_o = wel_i && !addr_prot_i;
          op_o     = OP_PROG;
        end
        CMD_SE, CMD_BE: begin
          accept_o = wel_i && !addr_prot_i;
          op_o     = OP_ERASE;
        end
        CMD_CE: begin
          accept_o = wel_i && (bp_i == '0);
          op_o     = OP_CHIP;
        end
        default: accept_o = 1'b0;
      endcase
    end
  end

  assign start_o = accept_o && (cmd_i != CMD_WREN) && (cmd_i != CMD_WRDI);
endmodule

// File: rtl/sfp_status_ctrl.sv
module sfp_status_ctrl
  import sfp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 17,
  parameter int unsigned T_WRSR  = 100,
  parameter int unsigned T_PP    = 400,
  parameter int unsigned T_ERASE = 3000,
  parameter int unsigned T_CE    = 20000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              wp_ni,
  input  logic              rd_status_i,
  output logic [7:0]        status_o,
  output logic              rd_valid_o,
  output logic [7:0]        rd_data_o,
  output logic              resp_valid_o,
  output logic              resp_accept_o,
  output logic              busy_o
);
  localparam int unsigned T_MAX01 = (T_WRSR > T_PP) ? T_WRSR : T_PP;
  localparam int unsigned T_MAX23 = (T_ERASE > T_CE) ? T_ERASE : T_CE;
  localparam int unsigned T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
  localparam int unsigned CNT_W   = $clog2(T_MAX + 1);

  cmd_e             cmd;
  logic [7:0]       nv_q;
  logic             wel_q;
  logic             wip;
  logic             srp;
  logic [BP_W-1:0]  bp;
  logic             addr_prot;
  logic             accept;
  logic             start;
  op_e              op;
  logic             op_done;
  logic [CNT_W-1:0] load_val;

  assign cmd = cmd_e'(cmd_i);
  assign srp = nv_q[SRP_BIT];
  assign bp  = nv_q[BP_LSB +: BP_W];

  sfp_range_check #(.ADDR_W(ADDR_W)) u_range (
    .bp_i   (bp),
    .addr_i (cmd_addr_i),
    .prot_o (addr_prot)
  );

  sfp_cmd_gate u_gate (
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd),
    .busy_i      (wip),
    .wel_i       (wel_q),
    .srp_i       (srp),
    .bp_i        (bp),
    .wp_ni       (wp_ni),
    .addr_prot_i (addr_prot),
    .accept_o    (accept),
    .start_o     (start),
    .op_o        (op)
  );

  always_comb begin
    unique case (op)
      OP_SR:    load_val = CNT_W'(T_WRSR);
      OP_PROG:  load_val = CNT_W'(T_PP);
      OP_ERASE: load_val = CNT_W'(T_ERASE);
      default:  load_val = CNT_W'(T_CE);
    endcase
  end

  sfp_busy_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (load_val),
    .busy_o     (wip),
    .done_o     (op_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
      nv_q  <= '0;
    end else begin
      if (accept && cmd == CMD_WREN)      wel_q <= 1'b1;
      else if (accept && cmd == CMD_WRDI) wel_q <= 1'b0;
      else if (op_done)                   wel_q <= 1'b0;
      if (accept && cmd == CMD_WRSR)      nv_q <= cmd_data_i & NV_MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      resp_accept_o <= 1'b0;
      rd_valid_o    <= 1'b0;
      rd_data_o     <= '0;
    end else begin
      resp_valid_o  <= cmd_valid_i;
      resp_accept_o <= accept;
      rd_valid_o    <= rd_status_i;
      if (rd_status_i) rd_data_o <= status_o;
    end
  end

  assign status_o = nv_q | {6'b0, wel_q, wip};
  assign busy_o   = wip;

  p_busy_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && busy_o |=> resp_valid_o && !resp_accept_o);
  p_no_wel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !status_o[1] && (cmd_i inside {3'd2, 3'd3, 3'd4, 3'd5, 3'd6})
    |=> !resp_accept_o);
  p_hw_lock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 3'd2 && status_o[7] && !wp_ni
    |=> $stable(status_o[7]) && $stable(status_o[4:2]));
  p_ce_guard_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 3'd6 && status_o[4:2] != 3'b000 |=> !resp_accept_o);
  p_wel_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !status_o[1]);
  p_resp_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !resp_valid_o && !resp_accept_o);
endmodule

// File: tb/sfp_status_ctrl_bench.sv
module sfp_status_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int TW = 4;
  localparam int TP = 6;
  localparam int TE = 9;
  localparam int TC = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd = 3'd0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = 8'h00;
  logic          wp_n = 1'b1;
  logic          rd_req = 1'b0;
  logic [7:0]    status, rd_data;
  logic          rd_valid, resp_valid, resp_accept, busy;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  exp_q[$];
  string tag_q[$];

  sfp_status_ctrl #(.ADDR_W(AW), .T_WRSR(TW), .T_PP(TP), .T_ERASE(TE), .T_CE(TC))
  u_sfp_status_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .cmd_addr_i(addr), .cmd_data_i(data), .wp_ni(wp_n), .rd_status_i(rd_req),
    .status_o(status), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .resp_valid_o(resp_valid), .resp_accept_o(resp_accept), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected accept flag for every response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) check_eq(1, 0, "R11 unexpected response");
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check_eq(int'(resp_accept), int'(e), t);
      end
    end
  end

  task automatic issue(input logic [2:0] c, input int a, input logic [7:0] d,
                       input bit acc, input string tag);
    cmd_valid = 1'b1;
    cmd  = c;
    addr = a[AW-1:0];
    data = d;
    exp_q.push_back(acc);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] exp, input string tag);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    check_eq(int'(rd_valid), 1, "R12 rd_valid");
    check_eq(int'(rd_data), int'(exp), tag);
  endtask

  task automatic busy_len(input int exp, input string tag);
    int n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check_eq(n, exp, tag);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    int base1, base3;
    base1 = (1 << AW) - (1 << (AW - 7 + 1));
    base3 = (1 << AW) - (1 << (AW - 7 + 3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check_eq(int'(busy), 0, "R1 busy after reset");
    rd_check(8'h00, "R1 status after reset");

    issue(3'd3, 0, 8'h00, 1'b0, "R3 program without WEL");
    rd_check(8'h00, "R9 state after reject");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    rd_check(8'h02, "R2 WEL set");
    issue(3'd1, 0, 8'h00, 1'b1, "R2 write disable");
    rd_check(8'h00, "R2 WEL cleared");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd3, 'h100, 8'h00, 1'b1, "R8 program accepted");
    busy_len(TP, "R8 program busy length");
    rd_check(8'h00, "R8 WEL cleared after program");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd4, 0, 8'h00, 1'b1, "R8 sector erase accepted");
    rd_check(8'h03, "R8 WIP and WEL during erase");
    issue(3'd0, 0, 8'h00, 1'b0, "R7 write enable while busy");
    rd_check(8'h03, "R7 state unchanged while busy");
    wait_idle();
    rd_check(8'h00, "R8 erase done");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd2, 0, 8'hFF, 1'b1, "R10 status write all ones");
    busy_len(TW, "R8 status write busy length");
    rd_check(8'h9C, "R10 only lock and BP stored");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd6, 0, 8'h00, 1'b0, "R5 chip erase with BP set");
    rd_check(8'h9E, "R9 WEL kept after reject");
    issue(3'd3, 0, 8'h00, 1'b0, "R4 BP=7 protects address 0");

    wp_n = 1'b0;
    issue(3'd2, 0, 8'h00, 1'b0, "R6 hardware lock");
    rd_check(8'h9E, "R6 lock and BP unchanged");
    wp_n = 1'b1;

    issue(3'd2, 0, 8'h6F, 1'b1, "R10 status write with pin high");
    busy_len(TW, "R8 status write busy length");
    rd_check(8'h0C, "R10 reserved and WEL/WIP data ignored");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd3, base3 - 1, 8'h00, 1'b1, "R4 BP=3 below boundary");
    wait_idle();
    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd3, base3, 8'h00, 1'b0, "R4 BP=3 at boundary");
    issue(3'd1, 0, 8'h00, 1'b1, "R2 write disable");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd2, 0, 8'h04, 1'b1, "R10 set BP=1");
    wait_idle();
    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd4, base1 - 1, 8'h00, 1'b1, "R4 BP=1 sector erase below boundary");
    busy_len(TE, "R8 erase busy length");
    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd5, base1, 8'h00, 1'b0, "R4 BP=1 block erase at boundary");
    issue(3'd5, 0, 8'h00, 1'b1, "R4 BP=1 block erase low address");
    busy_len(TE, "R8 block erase busy length");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd2, 0, 8'h00, 1'b1, "R10 clear BP");
    wait_idle();
    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd6, 0, 8'h00, 1'b1, "R5 chip erase with BP=0");
    busy_len(TC, "R8 chip erase busy length");
    rd_check(8'h00, "R8 WEL cleared after chip erase");

    issue(3'd0, 0, 8'h00, 1'b1, "R2 write enable");
    issue(3'd7, 0, 8'h00, 1'b0, "R11 code 7 rejected");
    rd_check(8'h02, "R11 code 7 no effect");

    repeat (3) @(negedge clk);
    check_eq(exp_q.size(), 0, "R11 all responses seen");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule